// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block sits between four peripheral DMA request lines and the system bus owner. When any peripheral asks for service, it raises a hold request to the CPU. Once the CPU signals through hold acknowledge that it has released the bus, the block hands the bus to exactly one channel by asserting that channel's acknowledge line. It also reports the index of the channel it has granted.

The winner is chosen by fixed priority (channel 0 first) or by rotating priority, in which the channel just served drops to the back of the queue. The choice between the two is latched from a mode bit when the mode-load strobe fires, and that strobe also returns the rotation to its starting point. A grant is held until the served channel reports end of service, whatever else is requested in the meantime. After a grant ends, the bus is only granted again once hold acknowledge has gone low and then high.

Top module: `dma_prio_arbiter`

## Requirements
- R1: Each request input is sampled through a two-stage synchronizer. From the idle state, a request present before rising edge 1 makes `hrq` high after rising edge 3 and no earlier.
- R2: In fixed mode (`rot_mode`=0 latched), the lowest-numbered pending channel wins. Channel k is granted as `dack` bit k, and `grant_idx`=k.
- R3: In rotating mode (`rot_mode`=1 latched), the search starts at the channel after the last one served, wrapping from 3 to 0. After reset, and after a mode load, it starts at channel 0.
- R4: No `dack` bit is set until `hlda` is sampled high while `hrq` is high. The grant appears after the first rising edge at which this holds.
- R5: A grant stays on the same channel until a rising edge at which `svc_done` is high. After that edge, `dack` is all zero, even if higher-priority requests arrived during the grant.
- R6: `dack` has at most one bit set, and it is all zero whenever `hlda` is low. While it is nonzero, `grant_idx` is the index of its set bit.
- R7: At the edge that ends service, `hrq` stays high if any synchronized request is pending, and otherwise drops. A new grant follows only after `hlda` has been sampled low and then high.
- R8: `mode_load` latches `rot_mode` and resets the rotation start to channel 0. It takes precedence over a rotation update in the same cycle.
- R9: A synchronous reset leaves `hrq`=0 and `dack`=0, selects fixed mode and sets the rotation start to channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| drq_async | input | 4 | Per-channel service requests, asynchronous, bit k = channel k |
| hlda | input | 1 | CPU hold acknowledge: bus released |
| rot_mode | input | 1 | Priority mode to latch: 0 fixed, 1 rotating |
| mode_load | input | 1 | Strobe that latches `rot_mode` and resets rotation |
| svc_done | input | 1 | End-of-service pulse for the granted channel |
| hrq | output | 1 | Hold request to the CPU |
| dack | output | 4 | One-hot channel acknowledge |
| grant_idx | output | 2 | Index of the granted channel |

## Verification
The results of this block are due at different times. A new request reaches `hrq` three rising edges after it is applied. A grant appears one edge after `hlda` is seen high in the asking state. The end of a grant shows one edge after `svc_done`. The `hlda` masking of `dack` is combinational and takes effect at once. The directed checks wait exactly those edge counts, and sample 2 ns after the edge at which the change is due. A behavioural model in the bench advances on every rising edge from the same inputs, and its outputs are compared with the design's outputs at every falling edge, across directed and random traffic.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    localparam int CH_N  = 4;
    localparam int IDX_W = $clog2(CH_N);

    typedef logic [CH_N-1:0]  ch_vec_t;
    typedef logic [IDX_W-1:0] ch_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASK  = 2'd1,
        ST_OWN  = 2'd2,
        ST_BACK = 2'd3
    } arb_state_e;

    typedef struct packed {
        logic    found;
        ch_idx_t idx;
    } pick_t;

    function automatic ch_idx_t wrap_inc(ch_idx_t i);
        if (int'(i) == CH_N - 1) return '0;
        return i + 1'b1;
    endfunction

    // First requesting channel met when walking upward from start.
    function automatic pick_t pick_first(ch_vec_t req, ch_idx_t start);
        pick_t r;
        int    pos;
        r = '0;
        for (int k = CH_N - 1; k >= 0; k--) begin
            pos = (int'(start) + k) % CH_N;
            if (req[pos]) begin
                r.found = 1'b1;
                r.idx   = ch_idx_t'(pos);
            end
        end
        return r;
    endfunction

    function automatic ch_vec_t to_onehot(ch_idx_t i);
        return ch_vec_t'(1) << i;
    endfunction
endpackage

// File: rtl/dpa_sync.sv
module dpa_sync #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [DEPTH-1:0][WIDTH-1:0] stg;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/dpa_prio.sv
module dpa_prio
    import dpa_pkg::*;
(
    input  ch_vec_t req,
    input  logic    rot,
    input  ch_idx_t base,
    output pick_t   pick
);
    ch_idx_t start;

    always_comb begin
        start = rot ? base : '0;
        pick  = pick_first(req, start);
    end
endmodule

// File: rtl/dpa_ctrl.sv
module dpa_ctrl
    import dpa_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_vec_t req,
    input  pick_t   pick,
    input  logic    hlda,
    input  logic    rot_in,
    input  logic    mode_load,
    input  logic    svc_done,
    output logic    rot_q,
    output ch_idx_t base_q,
    output logic    hrq,
    output ch_vec_t dack,
    output ch_idx_t grant_idx
);
    arb_state_e st;
    logic       keep_q;
    ch_idx_t    idx_q;
    logic       any_req;

    assign any_req = |req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            keep_q <= 1'b0;
            idx_q  <= '0;
            rot_q  <= 1'b0;
            base_q <= '0;
        end else begin
            if (mode_load) begin
                rot_q  <= rot_in;
                base_q <= '0;
            end else if (st == ST_OWN && svc_done && rot_q) begin
                base_q <= wrap_inc(idx_q);
            end

            unique case (st)
                ST_IDLE: if (any_req) st <= ST_ASK;
                ST_ASK: begin
                    if (hlda) begin
                        if (pick.found) begin
                            st    <= ST_OWN;
                            idx_q <= pick.idx;
                        end else begin
                            st     <= ST_BACK;
                            keep_q <= 1'b0;
                        end
                    end
                end
                ST_OWN: begin
                    if (svc_done) begin
                        st     <= ST_BACK;
                        keep_q <= any_req;
                    end
                end
                ST_BACK: if (!hlda) st <= keep_q ? ST_ASK : ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        hrq       = (st == ST_ASK) || (st == ST_OWN) || (st == ST_BACK && keep_q);
        dack      = (st == ST_OWN && hlda) ? to_onehot(idx_q) : '0;
        grant_idx = idx_q;
    end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dpa_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CH_N-1:0]  drq_async,
    input  logic             hlda,
    input  logic             rot_mode,
    input  logic             mode_load,
    input  logic             svc_done,
    output logic             hrq,
    output logic [CH_N-1:0]  dack,
    output logic [IDX_W-1:0] grant_idx
);
    ch_vec_t req_s;
    pick_t   pick;
    logic    rot_q;
    ch_idx_t base_q;

    dpa_sync #(.WIDTH(CH_N), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (drq_async),
        .dout (req_s)
    );

    dpa_prio u_prio (
        .req  (req_s),
        .rot  (rot_q),
        .base (base_q),
        .pick (pick)
    );

    dpa_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req_s),
        .pick      (pick),
        .hlda      (hlda),
        .rot_in    (rot_mode),
        .mode_load (mode_load),
        .svc_done  (svc_done),
        .rot_q     (rot_q),
        .base_q    (base_q),
        .hrq       (hrq),
        .dack      (dack),
        .grant_idx (grant_idx)
    );
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker (
    input logic       clk,
    input logic       rst,
    input logic       hlda,
    input logic       svc_done,
    input logic       hrq,
    input logic [3:0] dack,
    input logic [1:0] grant_idx
);
    AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack)); // R6

    AST_DACK_NEEDS_BUS: assert property (@(posedge clk) disable iff (rst)
        (dack != 4'b0) |-> (hlda && hrq)); // R6

    AST_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
        (dack != 4'b0) |-> dack[grant_idx]); // R6

    AST_NO_GRANT_WITHOUT_HRQ: assert property (@(posedge clk) disable iff (rst)
        !hrq |=> (dack == 4'b0)); // R4

    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dack != 4'b0 && !svc_done) |=> $stable(grant_idx)); // R5

    AST_END_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (dack != 4'b0 && svc_done) |=> (dack == 4'b0)); // R5
endmodule

bind dma_prio_arbiter dpa_checker u_dpa_checker (
    .clk       (clk),
    .rst       (rst),
    .hlda      (hlda),
    .svc_done  (svc_done),
    .hrq       (hrq),
    .dack      (dack),
    .grant_idx (grant_idx)
);

// File: tb/dma_prio_arbiter_bench.sv
`timescale 1ns/1ps
module dma_prio_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] drq_async = 4'b0;
    logic       hlda = 1'b0;
    logic       rot_mode = 1'b0;
    logic       mode_load = 1'b0;
    logic       svc_done = 1'b0;
    logic       hrq;
    logic [3:0] dack;
    logic [1:0] grant_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit started = 0;

    always #4 clk = ~clk;

    dma_prio_arbiter u_dma_prio_arbiter (
        .clk(clk), .rst(rst), .drq_async(drq_async), .hlda(hlda),
        .rot_mode(rot_mode), .mode_load(mode_load), .svc_done(svc_done),
        .hrq(hrq), .dack(dack), .grant_idx(grant_idx)
    );

    // Behavioural reference: 0 idle, 1 asking, 2 granted, 3 handing back
    logic [3:0] m_s1, m_s2;
    int m_st, m_idx, m_base;
    bit m_keep, m_rot;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_st = 0; m_idx = 0; m_base = 0; m_keep = 0; m_rot = 0;
        end else begin
            int o_st, o_idx, win;
            bit pend;
            o_st = m_st; o_idx = m_idx;
            pend = (m_s2 != 0);
            win = -1;
            for (int k = 0; k < 4; k++) begin
                int c;
                c = ((m_rot ? m_base : 0) + k) % 4;
                if (win < 0 && m_s2[c]) win = c;
            end
            case (o_st)
                0: if (pend) m_st = 1;
                1: if (hlda) begin
                       if (win >= 0) begin m_st = 2; m_idx = win; end
                       else begin m_st = 3; m_keep = 0; end
                   end
                2: if (svc_done) begin m_st = 3; m_keep = pend; end
                default: if (!hlda) m_st = m_keep ? 1 : 0;
            endcase
            if (mode_load) begin m_rot = rot_mode; m_base = 0; end
            else if (o_st == 2 && svc_done && m_rot) m_base = (o_idx + 1) % 4;
            m_s2 = m_s1;
            m_s1 = drq_async;
        end
        started = 1;
    end

    task automatic check_val(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst && !done) begin
            bit e_hrq;
            logic [3:0] e_dack;
            e_hrq  = (m_st == 1) || (m_st == 2) || (m_st == 3 && m_keep);
            e_dack = (m_st == 2 && hlda) ? (4'b1 << m_idx) : 4'b0;
            check_val("R7 model hrq", int'(hrq), int'(e_hrq));
            check_val("R6 model dack", int'(dack), int'(e_dack));
            if (e_dack != 0) check_val("R2 model grant_idx", int'(grant_idx), m_idx);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic end_service();
        svc_done = 1; tick(1); svc_done = 0;
    endtask

    task automatic rehandshake();
        hlda = 0; tick(1); hlda = 1; tick(1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 0;
        check_val("R9 reset hrq", int'(hrq), 0);
        check_val("R9 reset dack", int'(dack), 0);

        // R1 synchronizer latency, fixed mode
        drq_async = 4'b1010;
        tick(2); check_val("R1 hrq before third edge", int'(hrq), 0);
        tick(1); check_val("R1 hrq after third edge", int'(hrq), 1);
        tick(3); check_val("R4 no grant without hlda", int'(dack), 0);
        hlda = 1; tick(1);
        check_val("R2 fixed winner ch1", int'(dack), 4'b0010);
        check_val("R2 grant_idx ch1", int'(grant_idx), 1);

        // R5 higher request arrives during grant
        drq_async = 4'b1011; tick(4);
        check_val("R5 grant held on ch1", int'(dack), 4'b0010);

        // R6 hlda low masks dack
        hlda = 0; tick(1); check_val("R6 dack masked", int'(dack), 0);
        hlda = 1; tick(1); check_val("R6 dack back", int'(dack), 4'b0010);

        // R7 service ends with requests pending
        drq_async = 4'b1001; tick(3);
        end_service();
        check_val("R5 dack cleared after end", int'(dack), 0);
        check_val("R7 hrq kept", int'(hrq), 1);
        tick(2); check_val("R7 no regrant before hlda cycle", int'(dack), 0);
        rehandshake();
        check_val("R2 fixed winner ch0", int'(dack), 4'b0001);

        // R7 service ends with nothing pending
        drq_async = 4'b0000; tick(3);
        end_service();
        check_val("R7 hrq dropped", int'(hrq), 0);
        hlda = 0; tick(3);
        check_val("R7 idle hrq", int'(hrq), 0);

        // R8 / R3 rotating mode
        rot_mode = 1; mode_load = 1; tick(1); mode_load = 0;
        drq_async = 4'b1111; tick(3);
        check_val("R1 hrq rotating", int'(hrq), 1);
        hlda = 1; tick(1);
        check_val("R3 rotation starts ch0", int'(dack), 4'b0001);
        drq_async = 4'b1110; tick(3); end_service(); rehandshake();
        check_val("R3 rotation to ch1", int'(dack), 4'b0010);
        drq_async = 4'b1101; tick(3); end_service(); rehandshake();
        check_val("R3 rotation to ch2", int'(dack), 4'b0100);
        drq_async = 4'b0011; tick(3); end_service(); rehandshake();
        check_val("R3 rotation wraps to ch0", int'(dack), 4'b0001);
        mode_load = 1; svc_done = 1; tick(1); mode_load = 0; svc_done = 0;
        rehandshake();
        check_val("R8 load resets rotation", int'(dack), 4'b0001);
        end_service();
        mode_load = 1; rot_mode = 0; tick(1); mode_load = 0;
        rehandshake();
        check_val("R8 fixed mode latched", int'(dack), 4'b0001);

        // Random traffic compared against the model each cycle
        for (int i = 0; i < 600; i++) begin
            drq_async = 4'($urandom);
            if ($urandom % 5 == 0) hlda = ~hlda;
            svc_done  = (dack != 0) && ($urandom % 4 == 0);
            mode_load = ($urandom % 40 == 0);
            rot_mode  = 1'($urandom);
            tick(1);
        end
        svc_done = 0; mode_load = 0;
        tick(2);
        finish_run();
    end
endmodule